// File: doc/BRIEF.md
# Address-Windowed Bus Slave Memory

This block is a byte-wide memory that answers on a shared, arbitrated bus with a 16-bit address and 8-bit data. It stays quiet until any master is granted the bus. On the clock edge after that grant it captures the address and checks it against an inclusive window set by parameters. If the address is outside the window, the block takes no part in the transfer. If it is inside, the block holds the shared wait line high for a few cycles, then lowers it for one data cycle. In that cycle it either stores the bus byte or returns the stored byte, and after it the block lets go of the bus.

Several copies of the block, each with its own window, can tile the 64 KiB space. A typical layout is four equal quarters starting at 0x0000, 0x4000, 0x8000 and 0xC000. The storage in each copy covers only its own window, and it is indexed by the address minus the window base. The number of wait cycles comes from a free-running LFSR reduced modulo the maximum wait count plus one. This makes the stall pattern vary from transfer to transfer, yet repeat exactly after every reset.

The shared wait and data lines are modelled as a value plus an output enable. A pad or a bus mux at the chip level combines them. "Released" means that the enable is low.

Top module: `win_bus_slave`

## Requirements
- R1: With every grant bit low, the block never enables the wait line or the read-data line, whatever the address lines carry.
- R2: The address used for decoding is the one present at the first rising edge after the edge that sampled a grant bit high. The address present at the grant edge itself is ignored.
- R3: The block responds only when the captured address A satisfies ADDR_MIN <= A <= ADDR_MAX, both bounds included. A response is seen as wait_oe high in the cycle after the capture edge.
- R4: When responding, the block drives wait_drive=1 for between 0 and MAX_WAIT consecutive cycles, starting right after the capture edge. It then drives wait_drive=0 with wait_oe=1 for exactly one data cycle.
- R5: On a write (bus_write=1 at the capture edge), the byte on bus_wdata at the end of the data cycle is stored. Values driven during the wait cycles are not stored.
- R6: In the cycle after the data cycle, wait_oe and rdata_oe are both low. Both are also low after reset.
- R7: On a read, rdata_oe is high during the data cycle only, and rdata then carries the byte last written to that address.
- R8: A transfer outside the window leaves wait_oe and rdata_oe low throughout and changes no stored byte. This holds even for an out-of-window address whose low bits alias an in-window location.
- R9: The sequence of wait counts depends only on the time since reset. The same stimulus after two resets yields the same counts.
- R10: The wait count varies between transfers rather than staying fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | NMST | Grant bits, one per master |
| bus_addr | input | ADDR_W | Shared address lines |
| bus_write | input | 1 | 1 = write, 0 = read, sampled at the capture edge |
| bus_wdata | input | DATA_W | Shared data lines as driven by the master |
| wait_drive | output | 1 | Value this block puts on the shared wait line |
| wait_oe | output | 1 | Enable for wait_drive; low means released |
| rdata | output | DATA_W | Read byte this block puts on the data lines |
| rdata_oe | output | 1 | Enable for rdata; low means released |

## Verification
The bench builds the block with a window of 0x4000 to 0x7FFF, two masters and a maximum of four wait cycles. The window therefore has a neighbour on each side, so the addresses 0x3FFF, 0x4000, 0x7FFF and 0x8000 test both inclusive bounds. These settings also make 0x3FFF and 0x8000 alias in-window storage slots once the base is subtracted, so a stray write from a missed transfer would show up as corrupted data. The bench also changes the address between the grant edge and the capture edge, and it replays a fixed stimulus after two resets to compare the stall patterns.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_DATA = 2'd3
  } wbs_state_e;

endpackage

// File: rtl/wbs_wait_src.sv
// Free-running Galois LFSR reduced to the range 0..MAX_WAIT.
module wbs_wait_src #(
  parameter int                LFSR_W   = 8,
  parameter logic [LFSR_W-1:0] TAPS     = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED     = 8'hA5,
  parameter int                MAX_WAIT = 4,
  localparam int               CNT_W    = (MAX_WAIT > 0) ? $clog2(MAX_WAIT + 1) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);

  logic [LFSR_W-1:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= SEED;
    end else begin
      lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
    end
  end

  assign count = CNT_W'(lfsr_q % LFSR_W'(MAX_WAIT + 1));

endmodule

// File: rtl/wbs_window_decode.sv
// Inclusive window compare and window-relative index.
module wbs_window_decode #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] ADDR_MIN = 16'h0000,
  parameter logic [ADDR_W-1:0] ADDR_MAX = 16'h00FF,
  parameter int                IDX_W    = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  always_comb begin
    hit = (int'(addr) >= int'(ADDR_MIN)) && (int'(addr) <= int'(ADDR_MAX));
    idx = IDX_W'(addr - ADDR_MIN);
  end

endmodule

// File: rtl/wbs_byte_ram.sv
// Simple dual-port RAM: one write port, one registered read port.
module wbs_byte_ram #(
  parameter int DEPTH  = 256,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/win_bus_slave.sv
module win_bus_slave #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                NMST     = 2,
  parameter logic [ADDR_W-1:0] ADDR_MIN = 16'h0000,
  parameter logic [ADDR_W-1:0] ADDR_MAX = 16'h00FF,
  parameter int                MAX_WAIT = 4,
  parameter int                LFSR_W   = 8,
  parameter logic [LFSR_W-1:0] SEED     = 8'hA5,
  localparam int               WIN      = int'(ADDR_MAX) - int'(ADDR_MIN) + 1,
  localparam int               IDX_W    = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int               CNT_W    = (MAX_WAIT > 0) ? $clog2(MAX_WAIT + 1) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NMST-1:0]   bus_grant,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wait_drive,
  output logic              wait_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  import wbs_pkg::*;

  wbs_state_e       state_q;
  logic [CNT_W-1:0] rem_q;
  logic             we_q;
  logic [IDX_W-1:0] idx_q;

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] wcount;

  wbs_window_decode #(
    .ADDR_W  (ADDR_W),
    .ADDR_MIN(ADDR_MIN),
    .ADDR_MAX(ADDR_MAX),
    .IDX_W   (IDX_W)
  ) u_dec (
    .addr(bus_addr),
    .hit (hit),
    .idx (idx)
  );

  wbs_wait_src #(
    .LFSR_W  (LFSR_W),
    .SEED    (SEED),
    .MAX_WAIT(MAX_WAIT)
  ) u_wait (
    .clk  (clk),
    .rst  (rst),
    .count(wcount)
  );

  // Read is launched at the capture edge so a zero-wait read has data in
  // the very next cycle; the write lands at the end of the data cycle.
  logic ram_re, ram_we;
  assign ram_re = (state_q == ST_ADDR) && hit;
  assign ram_we = (state_q == ST_DATA) && we_q;

  wbs_byte_ram #(
    .DEPTH (WIN),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(idx_q),
    .wdata(bus_wdata),
    .re   (ram_re),
    .raddr(idx),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      we_q       <= 1'b0;
      idx_q      <= '0;
      wait_drive <= 1'b0;
      wait_oe    <= 1'b0;
      rdata_oe   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (|bus_grant) state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (hit) begin
            we_q    <= bus_write;
            idx_q   <= idx;
            wait_oe <= 1'b1;
            if (wcount != '0) begin
              wait_drive <= 1'b1;
              rem_q      <= wcount;
              state_q    <= ST_WAIT;
            end else begin
              wait_drive <= 1'b0;
              rdata_oe   <= ~bus_write;
              state_q    <= ST_DATA;
            end
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          rem_q <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            wait_drive <= 1'b0;
            rdata_oe   <= ~we_q;
            state_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          wait_oe  <= 1'b0;
          rdata_oe <= 1'b0;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                NMST     = 2,
  parameter logic [ADDR_W-1:0] ADDR_MIN = 16'h0000,
  parameter logic [ADDR_W-1:0] ADDR_MAX = 16'h00FF,
  parameter int                MAX_WAIT = 4,
  localparam int               WC_W     = $clog2(MAX_WAIT + 2) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NMST-1:0]   bus_grant,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wait_drive,
  input logic              wait_oe,
  input logic              rdata_oe
);

  logic [WC_W-1:0] wcnt_q;

  always_ff @(posedge clk) begin
    if (rst || !(wait_oe && wait_drive)) wcnt_q <= '0;
    else if (wcnt_q != '1)               wcnt_q <= wcnt_q + WC_W'(1);
  end

  // R6: reset leaves both lines released
  p_reset_release_r6: assert property (@(posedge clk)
    rst |=> (!wait_oe && !rdata_oe));

  // R1: a response needs a grant two edges earlier
  p_grant_before_drive_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_oe) |-> $past(|bus_grant, 2));

  // R3: a response needs the captured address inside the window
  p_window_hit_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_oe) |-> (int'($past(bus_addr)) >= int'(ADDR_MIN) &&
                        int'($past(bus_addr)) <= int'(ADDR_MAX)));

  // R4: wait stretch bounded
  p_wait_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    int'(wcnt_q) <= MAX_WAIT);

  // R6: data cycle is followed by release
  p_release_after_data_r6: assert property (@(posedge clk) disable iff (rst)
    (wait_oe && !wait_drive) |=> (!wait_oe && !rdata_oe));

  // R7: read data only in the data cycle, and for one cycle
  p_rdata_in_data_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> (wait_oe && !wait_drive));

  p_rdata_single_r7: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |=> !rdata_oe);

endmodule

bind win_bus_slave wbs_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NMST    (NMST),
  .ADDR_MIN(ADDR_MIN),
  .ADDR_MAX(ADDR_MAX),
  .MAX_WAIT(MAX_WAIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_grant (bus_grant),
  .bus_addr  (bus_addr),
  .wait_drive(wait_drive),
  .wait_oe   (wait_oe),
  .rdata_oe  (rdata_oe)
);

// File: tb/win_bus_slave_tb.sv
`timescale 1ns/1ps
module win_bus_slave_tb;

  localparam int MAXW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_grant = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        wait_drive, wait_oe, rdata_oe;
  logic [7:0]  rdata;

  always #2.5 clk = ~clk;

  win_bus_slave #(
    .ADDR_MIN(16'h4000),
    .ADDR_MAX(16'h7FFF),
    .MAX_WAIT(MAXW)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_grant(bus_grant), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .wait_drive(wait_drive),
    .wait_oe(wait_oe), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [logic [15:0]];
  bit seen_wait [int];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_grant = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One transfer as a master would run it. a_grant is on the lines at the
  // grant edge, a_cap at the capture edge. nwait returns -1 on a miss.
  task automatic xfer(input bit wr, input bit gsel, input logic [15:0] a_grant,
                      input logic [15:0] a_cap, input logic [7:0] d,
                      input bit exp_hit, output int nwait);
    logic [7:0] exp_rd;
    bus_grant = gsel ? 2'b10 : 2'b01;
    bus_addr  = a_grant;
    bus_write = wr;
    bus_wdata = ~d;
    @(negedge clk);               // grant edge passed
    bus_grant = '0;
    bus_addr  = a_cap;
    @(negedge clk);               // capture edge passed
    nwait = -1;
    if (!exp_hit) begin
      for (int k = 0; k < 4; k++) begin
        chk(!wait_oe && !rdata_oe, "R8", "miss left lines driven",
            {wait_oe, rdata_oe}, 0);
        @(negedge clk);
      end
      return;
    end
    chk(wait_oe === 1'b1, "R3", "in-window response", wait_oe, 1);
    nwait = 0;
    while (wait_drive === 1'b1 && nwait < 10) begin
      chk(!rdata_oe, "R7", "rdata during wait", rdata_oe, 0);
      nwait++;
      @(negedge clk);
    end
    chk(nwait <= MAXW, "R4", "wait cycle count", nwait, MAXW);
    chk(wait_oe === 1'b1 && wait_drive === 1'b0, "R4", "data cycle wait low",
        {wait_oe, wait_drive}, 2);
    bus_wdata = d;                // only this value must land (R5)
    if (wr) begin
      chk(!rdata_oe, "R7", "rdata_oe on write", rdata_oe, 0);
      shadow[a_cap] = d;
    end else begin
      exp_rd = shadow[a_cap];
      chk(rdata_oe === 1'b1, "R7", "rdata_oe in data cycle", rdata_oe, 1);
      chk(rdata === exp_rd, "R7", "read byte", rdata, exp_rd);
    end
    @(negedge clk);
    chk(!wait_oe && !rdata_oe, "R6", "release after data",
        {wait_oe, rdata_oe}, 0);
    seen_wait[nwait] = 1'b1;
  endtask

  typedef struct packed {
    logic        wr;
    logic        gsel;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        hit;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 16'h4000, 8'h11, 1'b1},
    '{1'b1, 1'b1, 16'h7FFF, 8'h22, 1'b1},
    '{1'b1, 1'b0, 16'h5A5A, 8'h33, 1'b1},
    '{1'b1, 1'b1, 16'h3FFF, 8'h44, 1'b0},   // below window, aliases 0x7FFF
    '{1'b1, 1'b0, 16'h8000, 8'h55, 1'b0},   // above window, aliases 0x4000
    '{1'b0, 1'b1, 16'h4000, 8'h00, 1'b1},
    '{1'b0, 1'b0, 16'h7FFF, 8'h00, 1'b1},
    '{1'b0, 1'b1, 16'h5A5A, 8'h00, 1'b1},
    '{1'b1, 1'b0, 16'h5A5A, 8'h3C, 1'b1},
    '{1'b0, 1'b0, 16'h5A5A, 8'h00, 1'b1},
    '{1'b0, 1'b1, 16'h3FFF, 8'h00, 1'b0},
    '{1'b0, 1'b0, 16'h8000, 8'h00, 1'b0},
    '{1'b1, 1'b1, 16'h6001, 8'hA5, 1'b1},
    '{1'b0, 1'b0, 16'h6001, 8'h00, 1'b1}
  };

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int nw;
    int run_a [6];
    int run_b [6];

    do_reset();
    // R6: reset state
    chk(!wait_oe && !rdata_oe, "R6", "reset state", {wait_oe, rdata_oe}, 0);

    // R1: in-window address but no grant
    bus_addr = 16'h4000; bus_write = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!wait_oe && !rdata_oe, "R1", "no grant, no drive",
          {wait_oe, rdata_oe}, 0);
    end

    // Table walk: R3, R4, R5, R7, R8 (0x3FFF/0x8000 miss writes must not alias)
    for (int i = 0; i < NV; i++) begin
      xfer(TBL[i].wr, TBL[i].gsel, TBL[i].addr, TBL[i].addr, TBL[i].data,
           TBL[i].hit, nw);
      @(negedge clk);
    end

    // R2: address at the grant edge is ignored, capture edge decides
    xfer(1'b1, 1'b0, 16'h8000, 16'h4100, 8'h77, 1'b1, nw);
    @(negedge clk);
    xfer(1'b0, 1'b1, 16'h4100, 16'h4100, 8'h00, 1'b1, nw);
    chk(nw >= 0, "R2", "late in-window address answered", nw, 0);
    @(negedge clk);
    xfer(1'b1, 1'b0, 16'h4100, 16'hC000, 8'hEE, 1'b0, nw);
    chk(nw == -1, "R2", "late out-of-window address ignored", nw, -1);
    xfer(1'b0, 1'b0, 16'h4100, 16'h4100, 8'h00, 1'b1, nw);

    // R10: the stall length is not constant
    chk(seen_wait.num() >= 2, "R10", "distinct wait counts", seen_wait.num(), 2);

    // R9: identical stimulus after reset gives identical waits
    do_reset();
    for (int i = 0; i < 6; i++) begin
      xfer(1'b1, 1'(i), 16'h4200 + 16'(i), 16'h4200 + 16'(i), 8'(i), 1'b1, run_a[i]);
      @(negedge clk);
    end
    do_reset();
    for (int i = 0; i < 6; i++) begin
      xfer(1'b1, 1'(i), 16'h4200 + 16'(i), 16'h4200 + 16'(i), 8'(i), 1'b1, run_b[i]);
      @(negedge clk);
    end
    for (int i = 0; i < 6; i++)
      chk(run_a[i] == run_b[i], "R9", "wait count repeats after reset",
          run_b[i], run_a[i]);

    // R5: byte stored is the data-cycle value, not the wait-phase value
    xfer(1'b0, 1'b0, 16'h4203, 16'h4203, 8'h00, 1'b1, nw);

    summary();
  end

endmodule